// File: doc/BRIEF.md
# Dual-Edge Pixel Bus Capture

This block receives a narrow pixel bus: a 12-bit data word with horizontal sync, vertical sync and a blanking flag, all launched alongside a pixel clock. It turns that bus into full pixels on the rising-edge clock domain. A 3-bit format code selects how the bus is read. In single-edge mode, one word is taken on each rising edge and becomes a pixel on its own. In dual-edge mode, a word is also taken on each falling edge, and the two halves of a clock period are joined into one 24-bit pixel.

The falling-edge half is moved into the rising-edge domain through a register. For that reason, every mode produces one pixel per rising edge with the same latency. The sync and blank flags are taken only from the rising-edge sample. They travel with the pixel data, so timing and data stay aligned at the output. The output valid strobe is low for blanked pixels. Dual-edge operation is meant for pixel rates up to 165 Mpixels/s.

Top module: `pixbus_capture`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs clear: `pix_out` = 0, `hs_out` = 0, `vs_out` = 0, `blank_out` = 1, `valid_out` = 0.
- R2: In single-edge mode, `pix_out[11:0]` is the word sampled at the rising edge and `pix_out[23:12]` is 0. The word sampled at the falling edge has no effect on any output.
- R3: In dual-edge mode, `pix_out[11:0]` is the word sampled at a rising edge. `pix_out[23:12]` is the word sampled at the falling edge that follows it.
- R4: The format code is sampled together with the rising-edge word. Values 3'b000 and 3'b001 select single-edge mode. Every other value (3'b010 to 3'b111) selects dual-edge mode for that pixel.
- R5: `hs_out`, `vs_out` and `blank_out` equal the `hs_in`, `vs_in` and `blank_in` levels sampled at the rising edge. Changes on those inputs between a rising edge and the next falling edge have no effect.
- R6: `valid_out` is the inverse of the sampled blank flag. Pixel data is still presented while blanked.
- R7: Inputs sampled at rising edge k appear on the outputs after rising edge k+1, giving one new pixel per rising edge with a fixed one-cycle latency and no dropped or repeated pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges used in dual-edge mode |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Format code selecting single- or dual-edge capture |
| din | input | 12 | Pixel bus data word |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| blank_in | input | 1 | Blanking flag |
| pix_out | output | 24 | Rebuilt pixel, rising-edge word in the low half |
| hs_out | output | 1 | Horizontal sync aligned with `pix_out` |
| vs_out | output | 1 | Vertical sync aligned with `pix_out` |
| blank_out | output | 1 | Blank flag aligned with `pix_out` |
| valid_out | output | 1 | High for each pixel that is not blanked |

## Verification
On every cycle, the embedded assertions check the following:
- the upper half is zero after a single-edge pixel;
- the upper half matches the falling-edge register after a dual-edge pixel;
- the low half and the sync flags follow their rising-edge registers by exactly one cycle;
- valid never rises on a blanked sample.

Only the bench scenarios can show that the right bus word reaches each register. These scenarios drive opposite values on the two edges, toggle the syncs in mid-cycle, sweep all eight format codes, change mode from one pixel to the next, and stream pixels back to back.

// File: rtl/pixbus_pkg.sv
package pixbus_pkg;
  localparam int FMT_W = 3;

  // Format codes 0 and 1 read the bus on the rising edge only; all others use both edges.
  function automatic logic pump_double(input logic [FMT_W-1:0] code);
    return (code > FMT_W'(1));
  endfunction
endpackage

// File: rtl/pixbus_rise_stage.sv
module pixbus_rise_stage
  import pixbus_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FMT_W-1:0]  fmt,
  input  logic [DATA_W-1:0] din,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              blank_in,
  output logic [DATA_W-1:0] lo_q,
  output logic              dbl_q,
  output logic              hs_q,
  output logic              vs_q,
  output logic              blank_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      dbl_q   <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      lo_q    <= din;
      dbl_q   <= pump_double(fmt);
      hs_q    <= hs_in;
      vs_q    <= vs_in;
      blank_q <= blank_in;
    end
  end
endmodule

// File: rtl/pixbus_fall_stage.sv
module pixbus_fall_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hi_q
);
  // Second half of each clock period; read by the rising-edge domain half a period later.
  always_ff @(negedge clk) begin
    if (rst) hi_q <= '0;
    else     hi_q <= din;
  end
endmodule

// File: rtl/pixbus_merge_stage.sv
module pixbus_merge_stage #(
  parameter int DATA_W = 12,
  localparam int PIX_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [DATA_W-1:0] hi_q,
  input  logic              dbl_q,
  input  logic              hs_q,
  input  logic              vs_q,
  input  logic              blank_q,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              blank_out,
  output logic              valid_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out   <= '0;
      hs_out    <= 1'b0;
      vs_out    <= 1'b0;
      blank_out <= 1'b1;
      valid_out <= 1'b0;
    end else begin
      pix_out   <= {(dbl_q ? hi_q : {DATA_W{1'b0}}), lo_q};
      hs_out    <= hs_q;
      vs_out    <= vs_q;
      blank_out <= blank_q;
      valid_out <= !blank_q;
    end
  end

  a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(dbl_q) |-> (pix_out[PIX_W-1:DATA_W] == '0));

  a_r3_upper_from_fall: assert property (@(posedge clk) disable iff (rst)
    $past(dbl_q) |-> (pix_out[PIX_W-1:DATA_W] == $past(hi_q)));

  a_r7_low_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pix_out[DATA_W-1:0] == $past(lo_q));

  a_r5_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (hs_out == $past(hs_q)) && (vs_out == $past(vs_q)) && (blank_out == $past(blank_q)));

  a_r6_no_valid_when_blank: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> !$past(blank_q));
endmodule

// File: rtl/pixbus_capture.sv
module pixbus_capture
  import pixbus_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int PIX_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FMT_W-1:0]  fmt,
  input  logic [DATA_W-1:0] din,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              blank_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              blank_out,
  output logic              valid_out
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic dbl_q, hs_q, vs_q, blank_q;

  pixbus_rise_stage #(.DATA_W(DATA_W)) u_rise (
    .clk(clk), .rst(rst), .fmt(fmt), .din(din),
    .hs_in(hs_in), .vs_in(vs_in), .blank_in(blank_in),
    .lo_q(lo_q), .dbl_q(dbl_q), .hs_q(hs_q), .vs_q(vs_q), .blank_q(blank_q)
  );

  pixbus_fall_stage #(.DATA_W(DATA_W)) u_fall (
    .clk(clk), .rst(rst), .din(din), .hi_q(hi_q)
  );

  pixbus_merge_stage #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst), .lo_q(lo_q), .hi_q(hi_q), .dbl_q(dbl_q),
    .hs_q(hs_q), .vs_q(vs_q), .blank_q(blank_q),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out),
    .blank_out(blank_out), .valid_out(valid_out)
  );

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!valid_out && blank_out));
endmodule

// File: tb/test_pixbus_capture.sv
module test_pixbus_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt = 3'd0;
  logic [11:0] din = '0;
  logic        hs_in = 1'b0, vs_in = 1'b0, blank_in = 1'b1;
  logic [23:0] pix_out;
  logic        hs_out, vs_out, blank_out, valid_out;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [23:0] pix;
    logic hs, vs, bl;
    string tag;
  } exp_t;
  exp_t pend[$];

  always #2.5 clk = ~clk;

  pixbus_capture i_pixbus_capture (
    .clk(clk), .rst(rst), .fmt(fmt), .din(din),
    .hs_in(hs_in), .vs_in(vs_in), .blank_in(blank_in),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out),
    .blank_out(blank_out), .valid_out(valid_out)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_front();
    exp_t e;
    if (pend.size() == 0) return;
    e = pend.pop_front();
    check(pix_out === e.pix, e.tag, "pix_out", {8'h0, pix_out}, {8'h0, e.pix});
    check({hs_out, vs_out, blank_out} === {e.hs, e.vs, e.bl}, "R5", "hs/vs/blank",
          {29'h0, hs_out, vs_out, blank_out}, {29'h0, e.hs, e.vs, e.bl});
    check(valid_out === !e.bl, "R6", "valid_out", {31'h0, valid_out}, {31'h0, !e.bl});
  endtask

  // Called just after a falling edge: presents the rising-edge word, then the falling-edge word.
  task automatic pixel(input logic [11:0] lo, input logic [11:0] hi, input logic hs,
                       input logic vs, input logic bl, input logic [2:0] f, input string tag);
    exp_t e;
    din = lo; hs_in = hs; vs_in = vs; blank_in = bl; fmt = f;
    @(posedge clk); #1;
    compare_front();               // R7: previous pixel appears one edge later
    e.pix = {((f == 3'd0 || f == 3'd1) ? 12'h000 : hi), lo};
    e.hs = hs; e.vs = vs; e.bl = bl; e.tag = tag;
    pend.push_back(e);
    din = hi;
    hs_in = ~hs; vs_in = ~vs; blank_in = ~bl; fmt = ~f;   // R5/R4: mid-cycle changes must not matter
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check(pix_out === 24'h0, "R1", "pix_out", {8'h0, pix_out}, 32'h0);
    check({hs_out, vs_out, blank_out, valid_out} === 4'b0010, "R1", "flags",
          {28'h0, hs_out, vs_out, blank_out, valid_out}, 32'h2);
    @(negedge clk); #1;
    rst = 1'b0;

    // R2: single-edge, falling word ignored
    pixel(12'hABC, 12'hFFF, 1'b0, 1'b0, 1'b0, 3'd0, "R2 R7");
    pixel(12'h123, 12'h555, 1'b1, 1'b0, 1'b0, 3'd1, "R2 R7");
    // R3: dual-edge pairing
    pixel(12'h456, 12'h789, 1'b0, 1'b1, 1'b0, 3'd2, "R3 R7");
    pixel(12'hFFF, 12'h000, 1'b1, 1'b1, 1'b0, 3'd7, "R3 R7");
    pixel(12'h000, 12'hFFF, 1'b0, 1'b0, 1'b0, 3'd5, "R3 R7");
    // R4: sweep all format codes with distinct halves
    for (int k = 0; k < 8; k++)
      pixel(12'h100 + 12'(k), 12'hE00 + 12'(k), k[0], k[1], 1'b0, 3'(k), "R4");
    // R6: blanked pixels keep data, valid drops
    pixel(12'h3A5, 12'h5A3, 1'b0, 1'b0, 1'b1, 3'd3, "R6 R3");
    pixel(12'h0F0, 12'h0F0, 1'b1, 1'b1, 1'b1, 3'd0, "R6 R2");
    pixel(12'h777, 12'h888, 1'b0, 1'b0, 1'b0, 3'd4, "R6 R3");
    // R7: alternating modes back to back
    for (int k = 0; k < 10; k++)
      pixel(12'(k * 37), 12'(4095 - k * 11), k[1], k[2], k[0] & k[2], (k % 2) ? 3'd6 : 3'd1, "R7 R4");
    // flush last pixel
    din = '0; hs_in = 1'b0; vs_in = 1'b0; blank_in = 1'b1; fmt = 3'd0;
    @(posedge clk); #1;
    compare_front();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule